// File: doc/BRIEF.md
# Bit Error Rate Monitor

This block measures the error rate of a received bit stream. An upstream comparison stage presents one strobe per received bit and, in the same cycle, a flag that says whether that bit was in error. The monitor counts the flagged bits over a measurement window of a fixed number of received bits. At the close of each window it captures the 16-bit error count, derives a coarse four-level rate grade from it, and starts the next window at once.

The result is only meaningful while the receive chain is locked. Three lock inputs (carrier, convolutional decoder sync and frame sync) are combined. Losing any of them throws away the window in progress and clears the valid flag. The same module serves two places in a receiver. The selectable variant picks one of four power-of-two windows through a 2-bit code and grades only in the code-10 window. The fixed variant, chosen by parameter, uses a packet-based window of 2,088,960 bits and always grades.

Top module: `ber_monitor`

## Requirements
- R1: After reset, the captured count reads 0, the grade reads 00 and `meas_vld` is low.
- R2: A bit is counted as an error only when `bit_err` and `bit_vld` are both high in the same cycle. An error strobe in a cycle without `bit_vld` is ignored.
- R3: In the selectable variant, `win_sel` codes 00, 01, 10 and 11 give windows of 2^WIN_LOG0, 2^WIN_LOG1, 2^WIN_LOG2 and 2^WIN_LOG3 valid bits. The defaults are 8, 16, 19 and 23.
- R4: In the fixed variant (`FIXED_MODE`=1) the window is FIXED_WIN valid bits (default 2,088,960), whatever `win_sel` holds.
- R5: On the clock edge that accepts the last bit of a window, the count of that window is captured, including an error on that last bit. It is visible after that edge. The running count clears, and the next valid bit is the first bit of a new window.
- R6: The running error count saturates at 0xFFFF and does not wrap.
- R7: Each of the following restarts the window, discards its partial count and drops `meas_vld` after the next edge: any of `lock_car`, `lock_vit` or `lock_frm` low, or a change of `win_sel`. The captured count is kept.
- R8: `meas_vld` rises only at the end of a complete window that ran entirely under lock.
- R9: The grade compares the captured count N against thresholds T_HI, T_MID and T_LO. The result is 00 if N ≥ T_HI, 01 if N ≥ T_MID, 10 if N ≥ T_LO, and 11 otherwise. The selectable defaults are 5243/524/52. The fixed-variant instance uses 20890/2089/209.
- R10: In the selectable variant the grade is forced to 00 for any window ended under a code other than GRADE_SEL (default 10).
- R11: `cnt_lo` carries bits 7:0 and `cnt_hi` bits 15:8 of the captured count. Both change only on the same window-end edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | One received bit this cycle |
| bit_err | input | 1 | The bit presented this cycle was in error |
| lock_car | input | 1 | Carrier lock |
| lock_vit | input | 1 | Convolutional decoder sync |
| lock_frm | input | 1 | Frame sync |
| win_sel | input | 2 | Window code (selectable variant) |
| cnt_lo | output | 8 | Captured error count, low byte |
| cnt_hi | output | 8 | Captured error count, high byte |
| grade | output | 2 | Four-level rate grade |
| meas_vld | output | 1 | Captured count and grade are valid |

## Verification
Every result is due one clock edge after the stimulus that causes it. The count, grade and valid flag update on the edge that accepts the last bit of a window. A lock drop or a code change clears the valid flag on the edge that first sees it. The bench drives each bit on a falling edge and reads the outputs on the next falling edge. Each check therefore lands half a cycle after the one register stage it depends on. In the back-to-back case the bench reads the first window's result while it drives the second window's first bit.

// File: rtl/ber_pkg.sv
package ber_pkg;

  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    GRADE_WORST = 2'b00,
    GRADE_HIGH  = 2'b01,
    GRADE_LOW   = 2'b10,
    GRADE_BEST  = 2'b11
  } ber_grade_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ber_window_timer.sv
module ber_window_timer #(
  parameter int unsigned BIT_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             bit_vld,
  input  logic [BIT_W-1:0] win_last,
  output logic             win_end
);

  logic [BIT_W-1:0] bit_cnt;

  assign win_end = bit_vld && !restart && (bit_cnt == win_last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      bit_cnt <= '0;
    end else if (bit_vld) begin
      if (win_end) bit_cnt <= '0;
      else         bit_cnt <= bit_cnt + 1'b1;
    end
  end

  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (bit_cnt <= win_last)); // R3

endmodule

// File: rtl/ber_err_counter.sv
module ber_err_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         win_end,
  output logic [W-1:0] run_cnt,
  output logic [W-1:0] final_cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign final_cnt = (inc && (run_cnt != TOP)) ? run_cnt + 1'b1 : run_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || win_end) run_cnt <= '0;
    else                       run_cnt <= final_cnt;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == TOP && inc && !clr && !win_end) |=> (run_cnt == TOP)); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !win_end) |=> ((run_cnt - $past(run_cnt)) <= 1)); // R2

endmodule

// File: rtl/ber_grader.sv
module ber_grader import ber_pkg::*; #(
  parameter int unsigned T_HI  = 5243,
  parameter int unsigned T_MID = 524,
  parameter int unsigned T_LO  = 52
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             grade_en,
  output ber_grade_e       grade
);

  localparam logic [CNT_W-1:0] TH_HI  = CNT_W'(T_HI);
  localparam logic [CNT_W-1:0] TH_MID = CNT_W'(T_MID);
  localparam logic [CNT_W-1:0] TH_LO  = CNT_W'(T_LO);

  always_comb begin
    if (!grade_en)           grade = GRADE_WORST;
    else if (cnt >= TH_HI)   grade = GRADE_WORST;
    else if (cnt >= TH_MID)  grade = GRADE_HIGH;
    else if (cnt >= TH_LO)   grade = GRADE_LOW;
    else                     grade = GRADE_BEST;
  end

endmodule

// File: rtl/ber_monitor.sv
module ber_monitor import ber_pkg::*; #(
  parameter bit          FIXED_MODE = 1'b0,
  parameter int unsigned FIXED_WIN  = 2088960,
  parameter int unsigned WIN_LOG0   = 8,
  parameter int unsigned WIN_LOG1   = 16,
  parameter int unsigned WIN_LOG2   = 19,
  parameter int unsigned WIN_LOG3   = 23,
  parameter int unsigned GRADE_SEL  = 2,
  parameter int unsigned T_HI       = 5243,
  parameter int unsigned T_MID      = 524,
  parameter int unsigned T_LO       = 52
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       bit_err,
  input  logic       lock_car,
  input  logic       lock_vit,
  input  logic       lock_frm,
  input  logic [1:0] win_sel,
  output logic [7:0] cnt_lo,
  output logic [7:0] cnt_hi,
  output logic [1:0] grade,
  output logic       meas_vld
);

  localparam int unsigned SEL_MAX_LOG = max_u(max_u(WIN_LOG0, WIN_LOG1), max_u(WIN_LOG2, WIN_LOG3));
  localparam int unsigned BIT_W       = FIXED_MODE ? $clog2(FIXED_WIN) : SEL_MAX_LOG;

  logic             all_lock;
  logic             restart;
  logic [1:0]       sel_q;
  logic [BIT_W-1:0] win_last;
  logic             win_end;
  logic             grade_en;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] final_cnt;
  logic [CNT_W-1:0] cnt_q;
  ber_grade_e       grade_nxt;
  ber_grade_e       grade_q;
  logic             vld_q;

  assign all_lock = lock_car && lock_vit && lock_frm;
  assign restart  = !all_lock || (win_sel != sel_q);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 2'b00;
    else     sel_q <= win_sel;
  end

  generate
    if (FIXED_MODE) begin : g_fixed
      assign win_last = BIT_W'(FIXED_WIN - 1);
      assign grade_en = 1'b1;
    end else begin : g_sel
      localparam logic [BIT_W-1:0] LAST0 = BIT_W'((64'd1 << WIN_LOG0) - 64'd1);
      localparam logic [BIT_W-1:0] LAST1 = BIT_W'((64'd1 << WIN_LOG1) - 64'd1);
      localparam logic [BIT_W-1:0] LAST2 = BIT_W'((64'd1 << WIN_LOG2) - 64'd1);
      localparam logic [BIT_W-1:0] LAST3 = BIT_W'((64'd1 << WIN_LOG3) - 64'd1);
      always_comb begin
        case (win_sel)
          2'b00:   win_last = LAST0;
          2'b01:   win_last = LAST1;
          2'b10:   win_last = LAST2;
          default: win_last = LAST3;
        endcase
      end
      assign grade_en = (win_sel == 2'(GRADE_SEL));
    end
  endgenerate

  ber_window_timer #(.BIT_W(BIT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .bit_vld  (bit_vld),
    .win_last (win_last),
    .win_end  (win_end)
  );

  ber_err_counter #(.W(CNT_W)) u_errs (
    .clk       (clk),
    .rst       (rst),
    .clr       (restart),
    .inc       (bit_vld && bit_err),
    .win_end   (win_end),
    .run_cnt   (run_cnt),
    .final_cnt (final_cnt)
  );

  ber_grader #(.T_HI(T_HI), .T_MID(T_MID), .T_LO(T_LO)) u_grade (
    .cnt      (final_cnt),
    .grade_en (grade_en),
    .grade    (grade_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      grade_q <= GRADE_WORST;
      vld_q   <= 1'b0;
    end else if (restart) begin
      vld_q   <= 1'b0;
    end else if (win_end) begin
      cnt_q   <= final_cnt;
      grade_q <= grade_nxt;
      vld_q   <= 1'b1;
    end
  end

  assign cnt_lo   = cnt_q[7:0];
  assign cnt_hi   = cnt_q[15:8];
  assign grade    = grade_q;
  assign meas_vld = vld_q;

  AST_NOLOCK_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    !all_lock |=> !meas_vld); // R7

  AST_BYTES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable({cnt_hi, cnt_lo})); // R11

  AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    $rose(meas_vld) |-> $past(win_end)); // R8

  generate
    if (!FIXED_MODE) begin : g_sel_chk
      AST_GRADE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (win_end && win_sel != 2'(GRADE_SEL)) |=> (grade == 2'b00)); // R10
    end
  endgenerate

endmodule

// File: tb/sim_ber_monitor.sv
module sim_ber_monitor;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v0 = 1'b0, e0 = 1'b0, v1 = 1'b0, e1 = 1'b0;
  logic lk_car = 1'b1, lk_vit = 1'b1, lk_frm = 1'b1;
  logic [1:0] sel0 = 2'b10;
  logic [7:0] lo0, hi0, lo1, hi1;
  logic [1:0] gr0, gr1;
  logic vd0, vd1;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ber_monitor #(.WIN_LOG0(2), .WIN_LOG1(3), .WIN_LOG2(4), .WIN_LOG3(16),
                .T_HI(8), .T_MID(4), .T_LO(2)) u0 (
    .clk(clk), .rst(rst), .bit_vld(v0), .bit_err(e0),
    .lock_car(lk_car), .lock_vit(lk_vit), .lock_frm(lk_frm), .win_sel(sel0),
    .cnt_lo(lo0), .cnt_hi(hi0), .grade(gr0), .meas_vld(vd0));

  ber_monitor #(.FIXED_MODE(1'b1), .FIXED_WIN(20), .T_HI(10), .T_MID(5), .T_LO(2)) u1 (
    .clk(clk), .rst(rst), .bit_vld(v1), .bit_err(e1),
    .lock_car(lk_car), .lock_vit(lk_vit), .lock_frm(lk_frm), .win_sel(2'b00),
    .cnt_lo(lo1), .cnt_hi(hi1), .grade(gr1), .meas_vld(vd1));

  function automatic logic [1:0] exp_grade(input int n, input int th, input int tm, input int tl);
    if (n >= th) return 2'b00;
    if (n >= tm) return 2'b01;
    if (n >= tl) return 2'b10;
    return 2'b11;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic drive0(input int n, input int nerr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); v0 = 1'b1; e0 = (i < nerr);
    end
    @(negedge clk); v0 = 1'b0; e0 = 1'b0;
  endtask

  task automatic drive1(input int n, input int nerr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); v1 = 1'b1; e1 = (i < nerr);
    end
    @(negedge clk); v1 = 1'b0; e1 = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 u0 count", {hi0, lo0}, 0);
    chk("R1 u0 grade", gr0, 2'b00);
    chk("R1 u0 valid", vd0, 0);
    chk("R1 u1 valid", vd1, 0);

    // R8 valid only after a full window (code 10, 16 bits)
    drive0(15, 0);
    chk("R8 partial window not valid", vd0, 0);
    drive0(1, 0);
    chk("R8 valid at window end", vd0, 1);
    chk("R5 count zero window", {hi0, lo0}, 0);

    // R3 R9 R5 sweep of error counts in the graded window
    for (int k = 0; k <= 16; k++) begin
      drive0(16, k);
      chk($sformatf("R5 count k=%0d", k), {hi0, lo0}, k);
      chk($sformatf("R9 grade k=%0d", k), gr0, exp_grade(k, 8, 4, 2));
      chk("R11 high byte", hi0, 0);
    end

    // R2 error strobes without bit_vld are ignored
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); v0 = 1'b1; e0 = (i < 3);
      @(negedge clk); v0 = 1'b0; e0 = 1'b1;
    end
    @(negedge clk); e0 = 1'b0;
    chk("R2 gated errors", {hi0, lo0}, 3);

    // R7 window code change restarts and drops valid
    @(negedge clk); sel0 = 2'b00;
    @(negedge clk);
    chk("R7 code change drops valid", vd0, 0);
    chk("R7 count held", {hi0, lo0}, 3);

    // R3 R10 windows for codes 00 and 01
    drive0(4, 3);
    chk("R3 code00 count", {hi0, lo0}, 3);
    chk("R10 code00 grade", gr0, 2'b00);
    @(negedge clk); sel0 = 2'b01;
    @(negedge clk);
    drive0(7, 1);
    chk("R3 code01 short not valid", vd0, 0);
    drive0(1, 1);
    chk("R3 code01 count", {hi0, lo0}, 2);
    chk("R10 code01 grade", gr0, 2'b00);

    // R5 back-to-back windows, code 00
    @(negedge clk); sel0 = 2'b00;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 4) chk("R5 first window latched", {hi0, lo0}, 2);
      v0 = 1'b1; e0 = (i == 2 || i == 3 || i == 4);
    end
    @(negedge clk); v0 = 1'b0; e0 = 1'b0;
    chk("R5 second window count", {hi0, lo0}, 1);

    // R7 each lock input
    for (int j = 0; j < 3; j++) begin
      drive0(2, 2);
      @(negedge clk);
      if (j == 0) lk_car = 1'b0; else if (j == 1) lk_vit = 1'b0; else lk_frm = 1'b0;
      @(negedge clk);
      lk_car = 1'b1; lk_vit = 1'b1; lk_frm = 1'b1;
      chk($sformatf("R7 lock%0d drops valid", j), vd0, 0);
      chk($sformatf("R7 lock%0d count held", j), {hi0, lo0}, (j == 0) ? 1 : j);
      drive0(4, j + 1);
      chk($sformatf("R7 lock%0d fresh window", j), {hi0, lo0}, j + 1);
    end

    // R4 fixed window of 20 bits
    drive1(19, 0);
    chk("R4 fixed partial not valid", vd1, 0);
    drive1(1, 0);
    chk("R4 fixed window valid", vd1, 1);
    for (int k = 0; k <= 20; k++) begin
      drive1(20, k);
      chk($sformatf("R4 fixed count k=%0d", k), {hi1, lo1}, k);
      chk($sformatf("R9 fixed grade k=%0d", k), gr1, exp_grade(k, 10, 5, 2));
    end

    // R6 saturation: code 11, 65536 bits all in error
    @(negedge clk); sel0 = 2'b11;
    @(negedge clk);
    drive0(65536, 65536);
    chk("R6 saturated count", {hi0, lo0}, 16'hFFFF);
    chk("R11 low byte saturated", lo0, 8'hFF);
    chk("R10 code11 grade", gr0, 2'b00);
    chk("R6 valid", vd0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule